// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block governs how instructions move through a register-rename stage of an out-of-order core, one thread at a time. Each cycle it compares the instructions waiting to be renamed with the back-end credits it receives: free reorder-buffer slots, issue-queue slots, load-queue slots, store-queue slots and free physical registers. From these it decides how many instructions go forward. The register mapping itself is left to other logic. This block only produces the counts and the flow-control decisions that the mapping logic and the decode stage act on.

Instructions that cannot go forward are held in a skid buffer inside the block. A status machine controls the stage. It has six states: idle, running, blocked, unblocking, squashing and serialize-stall. The block sends single-cycle block and unblock pulses back to decode. On a pipeline squash it empties the skid buffer. When the squash ends, it returns to one of three states, chosen by what the stage was doing when the squash arrived.

Top module: `rename_flow_ctrl`

## Requirements
- R1: The per-cycle budget is the smallest of free_rob, free_iq and the width W, where free_rob and free_iq are two's-complement signed. If the budget is zero or negative, nothing is renamed, and any waiting instructions are kept and the stage blocks.
- R2: When the budget is smaller than the number of waiting instructions, only the budget's worth go forward. The rest are written to the skid buffer and the state becomes blocked.
- R3: An instruction flagged as a load needs a load-queue credit, and one flagged as a store or atomic needs a store-queue credit. Credits used by earlier instructions in the same cycle are no longer available. The first instruction that lacks a credit, and every instruction after it, stays unrenamed.
- R4: An instruction with a destination needs a free physical register. If none is left, that instruction and every one after it stay waiting for a later cycle.
- R5: An instruction flagged as squashed that falls within the budget is discarded. It is counted on drop_cnt, uses no credit and is not counted on ren_cnt.
- R6: While stall_in is high in the idle, running or unblocking state, nothing is renamed, all arrivals go to the skid buffer and the state becomes blocked. block_o pulses for one cycle on entry to the blocked or serialize-stall state from any other state.
- R7: The blocked state moves to unblocking once stall_in is low. While unblocking, instructions are taken from the head of the skid buffer and new arrivals are appended behind them. In the cycle the buffer becomes empty, unblock_o pulses and the next state is running.
- R8: The skid buffer holds DEPTH entries. A push that does not fit raises skid_ovf_o, the excess arrivals are discarded, and skid_level never exceeds DEPTH.
- R9: squash_in empties the skid buffer and selects the squashing state. When squash_in falls, the next state is serialize-stall if the squash arrived during serialize-stall. Otherwise it is unblocking if the squash arrived while blocked or unblocking, and running in all other cases.
- R10: A serialize-before instruction stops renaming in front of itself, and the state becomes serialize-stall. That state holds until rob_empty is high, then moves to unblocking, where the held instruction is allowed through from the skid-buffer head.
- R11: A renamed serialize-after instruction makes the next non-squashed instruction act as serialize-before, whether that instruction arrives in the same cycle or a later one.
- R12: state_o encodes idle=0, running=1, blocked=2, unblocking=3, squashing=4, serialize-stall=5. After reset the state is idle with an empty skid buffer. A running cycle with no instructions leads to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | $clog2(W+1) | Number of instructions arriving from decode this cycle |
| dec_ld | input | W | Per-slot load flag |
| dec_st | input | W | Per-slot store-or-atomic flag |
| dec_dst | input | W | Per-slot needs-destination-register flag |
| dec_sqd | input | W | Per-slot already-squashed flag |
| dec_sb | input | W | Per-slot serialize-before flag |
| dec_sa | input | W | Per-slot serialize-after or store-conditional flag |
| free_rob | input | CW | Free reorder-buffer entries, signed |
| free_iq | input | CW | Free issue-queue entries, signed |
| free_lq | input | CW | Free load-queue entries |
| free_sq | input | CW | Free store-queue entries |
| free_preg | input | CW | Free physical registers |
| stall_in | input | 1 | Back-end stall request |
| squash_in | input | 1 | Pipeline squash |
| rob_empty | input | 1 | Reorder buffer is empty |
| ren_cnt | output | $clog2(W+1) | Instructions renamed this cycle |
| drop_cnt | output | $clog2(W+1) | Squashed instructions discarded this cycle |
| push_cnt | output | $clog2(W+1) | Entries written to the skid buffer this cycle |
| pop_cnt | output | $clog2(W+1) | Entries removed from the skid buffer this cycle |
| skid_level | output | $clog2(DEPTH+1) | Skid buffer occupancy |
| block_o | output | 1 | Block pulse toward decode |
| unblock_o | output | 1 | Unblock pulse toward decode |
| skid_ovf_o | output | 1 | Skid buffer overflow this cycle |
| state_o | output | 3 | Stage status |

## Verification
The bench sweeps every combination of a small grid of signed ROB and IQ credits, LQ, SQ and register credits, arrival counts and load/store/destination/squashed patterns from a running start. In each case it compares the renamed, dropped and pushed counts and the resulting state with values it computes arithmetically. A design that did not carry the load and store credits forward within a cycle would rename too many memory operations. A design that ignored negative credits, or charged squashed instructions for resources, would produce wrong counts.

Directed sequences cover three paths: squash recovery into each of its three destinations, a serialize-before instruction caught mid-group and then let through from the buffer head, and a serialize-after instruction that is the last one renamed in a cycle. A design that dropped the pending-serialize flag across cycles would let the next instruction through without stalling. A design that did not clear the bypass at the buffer head would stall forever. A final run that fills the skid buffer confirms that the overflow flag rises and that occupancy stays at its limit.

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 6,
  localparam int CNTW = $clog2(W + 1),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNTW-1:0]      dec_cnt,
  input  logic [W-1:0]         dec_ld,
  input  logic [W-1:0]         dec_st,
  input  logic [W-1:0]         dec_dst,
  input  logic [W-1:0]         dec_sqd,
  input  logic [W-1:0]         dec_sb,
  input  logic [W-1:0]         dec_sa,
  input  logic signed [CW-1:0] free_rob,
  input  logic signed [CW-1:0] free_iq,
  input  logic [CW-1:0]        free_lq,
  input  logic [CW-1:0]        free_sq,
  input  logic [CW-1:0]        free_preg,
  input  logic                 stall_in,
  input  logic                 squash_in,
  input  logic                 rob_empty,
  output logic [CNTW-1:0]      ren_cnt,
  output logic [CNTW-1:0]      drop_cnt,
  output logic [CNTW-1:0]      push_cnt,
  output logic [CNTW-1:0]      pop_cnt,
  output logic [LW-1:0]        skid_level,
  output logic                 block_o,
  output logic                 unblock_o,
  output logic                 skid_ovf_o,
  output logic [2:0]           state_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 6;
  localparam int B_SQD = 5, B_LD = 4, B_ST = 3, B_DST = 2, B_SB = 1, B_SA = 0;

  localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2,
                         S_UNB  = 3'd3, S_SQSH = 3'd4, S_SER = 3'd5;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [LW-1:0] level;
  logic [2:0]    st_q, st_d;
  logic          ser_next_q, head_ok_q, res_ser_q, res_unb_q;

  logic [EW-1:0] dec_e [W];
  logic [EW-1:0] win   [W];

  wire from_skid = (st_q == S_UNB);
  wire run_ok    = !squash_in && !stall_in &&
                   (st_q == S_IDLE || st_q == S_RUN || st_q == S_UNB);

  always_comb begin
    for (int i = 0; i < W; i++) begin
      dec_e[i] = {dec_sqd[i], dec_ld[i], dec_st[i], dec_dst[i], dec_sb[i], dec_sa[i]};
      win[i]   = from_skid ? mem[PW'((int'(head) + i) % DEPTH)] : dec_e[i];
    end
  end

  int   dec_n, avail, bud, lim, n_proc, n_ren, n_drop;
  int   lqc, sqc, prc;
  logic pend, stop, ser_hit, pend_end;

  always_comb begin
    dec_n = (int'(dec_cnt) > W) ? W : int'(dec_cnt);
    avail = from_skid ? ((int'(level) > W) ? W : int'(level)) : dec_n;
    bud   = (int'(free_rob) < int'(free_iq)) ? int'(free_rob) : int'(free_iq);
    if (bud > W) bud = W;
    lim   = (!run_ok || bud <= 0) ? 0 : ((bud < avail) ? bud : avail);
    lqc   = int'(free_lq);
    sqc   = int'(free_sq);
    prc   = int'(free_preg);
    pend    = ser_next_q;
    stop    = 1'b0;
    ser_hit = 1'b0;
    n_proc  = 0;
    n_ren   = 0;
    n_drop  = 0;
    for (int i = 0; i < W; i++) begin
      if (i < lim && !stop) begin
        if (win[i][B_SQD]) begin
          n_drop++;
          n_proc++;
        end else if ((win[i][B_SB] || pend) && !(i == 0 && from_skid && head_ok_q)) begin
          stop    = 1'b1;
          ser_hit = 1'b1;
        end else if (win[i][B_LD] && lqc == 0) begin
          stop = 1'b1;
        end else if (win[i][B_ST] && sqc == 0) begin
          stop = 1'b1;
        end else if (win[i][B_DST] && prc == 0) begin
          stop = 1'b1;
        end else begin
          n_ren++;
          n_proc++;
          if (win[i][B_LD])  lqc--;
          if (win[i][B_ST])  sqc--;
          if (win[i][B_DST]) prc--;
          pend = win[i][B_SA];
        end
      end
    end
    pend_end = pend;
  end

  int   first, push_n, pop_n, space, wr_n, lvl_nx;
  logic ovf;

  always_comb begin
    if (squash_in || st_q == S_SQSH) begin
      first  = 0;
      push_n = 0;
    end else if (run_ok && !from_skid) begin
      first  = n_proc;
      push_n = dec_n - n_proc;
    end else begin
      first  = 0;
      push_n = dec_n;
    end
    pop_n  = (run_ok && from_skid) ? n_proc : 0;
    space  = DEPTH - (int'(level) - pop_n);
    ovf    = push_n > space;
    wr_n   = ovf ? space : push_n;
    lvl_nx = int'(level) - pop_n + wr_n;
  end

  wire need_block = (n_proc < avail) && !ser_hit;

  always_comb begin
    st_d = st_q;
    if (squash_in) begin
      st_d = S_SQSH;
    end else begin
      case (st_q)
        S_SQSH:  st_d = res_ser_q ? S_SER : (res_unb_q ? S_UNB : S_RUN);
        S_BLK:   st_d = stall_in ? S_BLK : S_UNB;
        S_SER:   st_d = rob_empty ? S_UNB : S_SER;
        default: begin
          if (stall_in)        st_d = S_BLK;
          else if (ser_hit)    st_d = S_SER;
          else if (need_block) st_d = S_BLK;
          else if (from_skid)  st_d = (lvl_nx == 0) ? S_RUN : S_UNB;
          else                 st_d = (avail == 0) ? S_IDLE : S_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      head       <= '0;
      tail       <= '0;
      level      <= '0;
      ser_next_q <= 1'b0;
      head_ok_q  <= 1'b0;
      res_ser_q  <= 1'b0;
      res_unb_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (squash_in) begin
        head       <= '0;
        tail       <= '0;
        level      <= '0;
        ser_next_q <= 1'b0;
        head_ok_q  <= 1'b0;
        if (st_q != S_SQSH) begin
          res_ser_q <= (st_q == S_SER);
          res_unb_q <= (st_q == S_BLK) || (st_q == S_UNB);
        end
      end else begin
        head  <= PW'((int'(head) + pop_n) % DEPTH);
        tail  <= PW'((int'(tail) + wr_n) % DEPTH);
        level <= LW'(lvl_nx);
        if (run_ok && n_ren > 0) ser_next_q <= pend_end;
        if (st_q == S_SER && st_d == S_UNB)        head_ok_q <= 1'b1;
        else if (run_ok && from_skid && n_ren > 0) head_ok_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!squash_in) begin
      for (int k = 0; k < W; k++) begin
        if (k < wr_n) mem[PW'((int'(tail) + k) % DEPTH)] <= dec_e[first + k];
      end
    end
  end

  assign ren_cnt    = CNTW'(n_ren);
  assign drop_cnt   = CNTW'(n_drop);
  assign push_cnt   = CNTW'(wr_n);
  assign pop_cnt    = CNTW'(pop_n);
  assign skid_level = level;
  assign skid_ovf_o = ovf;
  assign state_o    = st_q;
  assign block_o    = (st_d == S_BLK || st_d == S_SER) && !(st_q == S_BLK || st_q == S_SER);
  assign unblock_o  = (st_q == S_UNB) && (st_d == S_RUN);
endmodule

// File: rtl/rename_flow_ctrl_chk.sv
module rename_flow_ctrl_chk #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 6,
  localparam int CNTW = $clog2(W + 1),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [CW-1:0] free_rob,
  input logic signed [CW-1:0] free_iq,
  input logic                 stall_in,
  input logic                 squash_in,
  input logic                 rob_empty,
  input logic [CNTW-1:0]      ren_cnt,
  input logic [CNTW-1:0]      drop_cnt,
  input logic [LW-1:0]        skid_level,
  input logic                 block_o,
  input logic                 unblock_o,
  input logic [2:0]           state_o
);
  // R1
  ren_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_cnt == '0 || ($signed({1'b0, ren_cnt}) <= free_rob && $signed({1'b0, ren_cnt}) <= free_iq));

  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_in |-> (ren_cnt == '0 && drop_cnt == '0));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({block_o, unblock_o}));

  // R7
  unblock_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_o |=> (skid_level == '0 && state_o == 3'd1));

  // R8
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(skid_level) <= DEPTH);

  // R9
  squash_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_in |=> (state_o == 3'd4 && skid_level == '0));

  // R10
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !rob_empty && !squash_in) |=> state_o == 3'd5);

  // R12
  halted_no_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 || state_o == 3'd4 || state_o == 3'd5) |-> ren_cnt == '0);
endmodule

bind rename_flow_ctrl rename_flow_ctrl_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .free_rob(free_rob), .free_iq(free_iq),
  .stall_in(stall_in), .squash_in(squash_in), .rob_empty(rob_empty),
  .ren_cnt(ren_cnt), .drop_cnt(drop_cnt), .skid_level(skid_level),
  .block_o(block_o), .unblock_o(unblock_o), .state_o(state_o)
);

// File: tb/rename_flow_ctrl_tb.sv
module rename_flow_ctrl_tb;
  localparam int W = 4, DEPTH = 8, CW = 6;
  localparam int CNTW = $clog2(W + 1), LW = $clog2(DEPTH + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNTW-1:0] dec_cnt = '0;
  logic [W-1:0] dec_ld = '0, dec_st = '0, dec_dst = '0, dec_sqd = '0, dec_sb = '0, dec_sa = '0;
  logic signed [CW-1:0] free_rob = 6'sd20, free_iq = 6'sd20;
  logic [CW-1:0] free_lq = 6'd8, free_sq = 6'd8, free_preg = 6'd20;
  logic stall_in = 1'b0, squash_in = 1'b0, rob_empty = 1'b0;
  logic [CNTW-1:0] ren_cnt, drop_cnt, push_cnt, pop_cnt;
  logic [LW-1:0] skid_level;
  logic block_o, unblock_o, skid_ovf_o;
  logic [2:0] state_o;

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rename_flow_ctrl #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_dut (.*);

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int n, input logic [W-1:0] ld, st, dst, sqd, sb, sa);
    dec_cnt = CNTW'(n); dec_ld = ld; dec_st = st; dec_dst = dst;
    dec_sqd = sqd; dec_sb = sb; dec_sa = sa;
  endtask

  task automatic idle_in();
    drive(0, '0, '0, '0, '0, '0, '0);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    idle_in();
    stall_in = 0; squash_in = 0; rob_empty = 0;
    free_rob = 6'sd20; free_iq = 6'sd20; free_lq = 6'd8; free_sq = 6'd8; free_preg = 6'd20;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int robv[5] = '{-1, 0, 1, 3, 8};
    int iqv[3]  = '{0, 2, 8};
    int prv[4]  = '{0, 1, 2, 4};

    restart();
    #1;
    check(int'(state_o), 0, "R12 reset state");
    check(int'(skid_level), 0, "R12 reset level");
    check(int'(block_o), 0, "R12 reset block");

    // Sweep from a running start: R1 R2 R3 R4 R5
    for (int a = 0; a < 5; a++)
    for (int b = 0; b < 3; b++)
    for (int lq = 0; lq < 3; lq++)
    for (int sq = 0; sq < 3; sq++)
    for (int c = 0; c < 4; c++)
    for (int n = 0; n <= W; n++)
    for (int p = 0; p < 8; p++) begin
      logic [W-1:0] ld, st, dst, sqd;
      int bud, lim, np, er, ed, lqc, sqc, prc;
      logic stop;
      for (int i = 0; i < W; i++) begin
        ld[i]  = ((p + i) % 3) == 0;
        st[i]  = ((p + i) % 3) == 1;
        dst[i] = ((p * 3 + i) % 4) != 3;
        sqd[i] = (p == 5 && i == 1) || (p == 6 && i == 0);
      end
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      free_rob = CW'(robv[a]); free_iq = CW'(iqv[b]);
      free_lq = CW'(lq); free_sq = CW'(sq); free_preg = CW'(prv[c]);
      drive(n, ld, st, dst, sqd, '0, '0);
      bud = (robv[a] < iqv[b]) ? robv[a] : iqv[b];
      if (bud > W) bud = W;
      lim = (bud <= 0) ? 0 : ((bud < n) ? bud : n);
      np = 0; er = 0; ed = 0; lqc = lq; sqc = sq; prc = prv[c]; stop = 0;
      for (int i = 0; i < lim; i++) begin
        if (!stop) begin
          if (sqd[i]) begin ed++; np++; end
          else if ((ld[i] && lqc == 0) || (st[i] && sqc == 0) || (dst[i] && prc == 0)) stop = 1;
          else begin
            er++; np++;
            if (ld[i]) lqc--;
            if (st[i]) sqc--;
            if (dst[i]) prc--;
          end
        end
      end
      #1;
      check(int'(ren_cnt), er, "R1/R3/R4 renamed count");
      check(int'(drop_cnt), ed, "R5 dropped count");
      check(int'(push_cnt), n - np, "R2 skid push");
      check(int'(block_o), (np < n) ? 1 : 0, "R2 block pulse");
      @(negedge clk);
      idle_in();
      check(int'(state_o), (n == 0) ? 0 : ((np < n) ? 2 : 1), "R12 state after sweep vector");
      check(int'(skid_level), n - np, "R2 skid level");
    end

    // R6/R7 stall, block, unblock
    restart();
    stall_in = 1; drive(3, '0, '0, 4'hF, '0, '0, '0);
    #1;
    check(int'(ren_cnt), 0, "R6 no rename on stall");
    check(int'(push_cnt), 3, "R6 arrivals pushed");
    check(int'(block_o), 1, "R6 block pulse");
    @(negedge clk); idle_in();
    check(int'(state_o), 2, "R6 blocked");
    check(int'(skid_level), 3, "R6 level");
    stall_in = 0;
    @(negedge clk);
    check(int'(state_o), 3, "R7 unblocking");
    #1;
    check(int'(ren_cnt), 3, "R7 renamed from skid");
    check(int'(pop_cnt), 3, "R7 popped");
    check(int'(unblock_o), 1, "R7 unblock pulse");
    @(negedge clk);
    check(int'(state_o), 1, "R7 running after drain");
    check(int'(skid_level), 0, "R7 empty");

    // R9 squash while blocked -> unblocking
    restart();
    stall_in = 1; drive(2, '0, '0, 4'hF, '0, '0, '0);
    @(negedge clk); idle_in();
    stall_in = 0; squash_in = 1;
    @(negedge clk);
    check(int'(state_o), 4, "R9 squashing");
    check(int'(skid_level), 0, "R9 flushed");
    squash_in = 0;
    @(negedge clk);
    check(int'(state_o), 3, "R9 resume to unblocking");
    #1;
    check(int'(unblock_o), 1, "R9 unblock after resume");
    @(negedge clk);
    check(int'(state_o), 1, "R9 running");

    // R9 squash while running -> running
    restart();
    drive(1, '0, '0, 4'hF, '0, '0, '0);
    @(negedge clk); idle_in();
    squash_in = 1;
    @(negedge clk);
    squash_in = 0;
    @(negedge clk);
    check(int'(state_o), 1, "R9 resume to running");

    // R10 serialize-before mid-group
    restart();
    drive(3, '0, '0, 4'hF, '0, 4'b0010, '0);
    #1;
    check(int'(ren_cnt), 1, "R10 stop before serializer");
    check(int'(push_cnt), 2, "R10 remainder pushed");
    check(int'(block_o), 1, "R10 block pulse");
    @(negedge clk); idle_in();
    check(int'(state_o), 5, "R10 serialize stall");
    check(int'(skid_level), 2, "R10 level");
    @(negedge clk);
    check(int'(state_o), 5, "R10 holds without empty ROB");
    rob_empty = 1;
    @(negedge clk);
    rob_empty = 0;
    check(int'(state_o), 3, "R10 to unblocking");
    #1;
    check(int'(ren_cnt), 2, "R10 serializer passes at head");
    check(int'(unblock_o), 1, "R10 unblock");
    @(negedge clk);
    check(int'(state_o), 1, "R10 running");

    // R9 squash during serialize stall -> serialize stall
    restart();
    drive(1, '0, '0, 4'hF, '0, 4'b0001, '0);
    @(negedge clk); idle_in();
    check(int'(state_o), 5, "R10 lone serializer stalls");
    squash_in = 1;
    @(negedge clk);
    squash_in = 0;
    @(negedge clk);
    check(int'(state_o), 5, "R9 resume to serialize stall");

    // R11 serialize-after within a group
    restart();
    drive(2, '0, '0, 4'hF, '0, '0, 4'b0001);
    #1;
    check(int'(ren_cnt), 1, "R11 next after marker stalls");
    @(negedge clk); idle_in();
    check(int'(state_o), 5, "R11 serialize stall");
    rob_empty = 1;
    @(negedge clk);
    rob_empty = 0;
    #1;
    check(int'(ren_cnt), 1, "R11 held instruction renamed");
    @(negedge clk);
    check(int'(state_o), 1, "R11 running");

    // R11 serialize-after last in cycle
    restart();
    drive(2, '0, '0, 4'hF, '0, '0, 4'b0010);
    #1;
    check(int'(ren_cnt), 2, "R11 marker last in group");
    @(negedge clk);
    check(int'(state_o), 1, "R11 still running");
    drive(1, '0, '0, 4'hF, '0, '0, '0);
    #1;
    check(int'(ren_cnt), 0, "R11 next cycle instruction serialized");
    @(negedge clk); idle_in();
    check(int'(state_o), 5, "R11 stall across cycles");

    // R8 overflow
    restart();
    stall_in = 1; drive(4, '0, '0, 4'hF, '0, '0, '0);
    @(negedge clk);
    #1;
    check(int'(skid_ovf_o), 0, "R8 no overflow at half");
    @(negedge clk);
    check(int'(skid_level), 8, "R8 full");
    #1;
    check(int'(skid_ovf_o), 1, "R8 overflow flagged");
    check(int'(push_cnt), 0, "R8 excess discarded");
    @(negedge clk); idle_in();
    check(int'(skid_level), 8, "R8 level capped");
    stall_in = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule